// File: doc/BRIEF.md
# Asynchronous Serial Channel with Modem Gating

This block is one full-duplex asynchronous serial channel. A byte-wide register port sets the frame shape (7 or 8 data bits, optional parity, optional ninth bit for multiprocessor addressing, one or two stop bits) and a 16-bit baud divisor. Software writes a byte to a single transmit holding register and reads received bytes from a single receive data register. Sticky status bits report parity, framing and overrun errors.

Two active-low modem inputs gate the channel in different ways. While the carrier-detect input is inactive, the receiver is held idle and no frame can arrive. While the clear-to-send input is inactive, only the transmit-ready status bit is hidden; the transmitter keeps sending. The request-to-send output follows a control bit. One interrupt line combines receive-ready and transmit-ready, each with its own enable.

Register map (3-bit address): 0 mode, 1 auxiliary, 2 divisor low byte, 3 divisor high byte, 4 status (a write of any value clears the error bits), 5 data (a write fills the holding register, a read returns received data). Mode bits: 0 receiver on, 1 transmitter on, 2 eight data bits (else seven), 3 parity on, 4 odd parity (else even), 5 two stop bits, 6 ninth-bit mode, 7 request-to-send. Auxiliary bits: 0 ninth bit to send, 1 receive interrupt enable, 2 transmit interrupt enable. Status bits: 0 receive ready, 1 transmit ready, 2 parity error, 3 framing error, 4 overrun, 5 last received ninth bit, 6 carrier present.

Top module: `serial_link_port`

## Requirements
- R1: A frame on txd is a 0 start bit, then data least significant bit first (8 bits when mode bit 2 is set, else 7), then the optional extra bit, then 1 or 2 stop bits at 1 (two when mode bit 5 is set). txd idles at 1, and frames are sent only while mode bit 1 is set.
- R2: When mode bit 3 is set and mode bit 6 is clear, a parity bit follows the data. It is even parity, or odd parity when mode bit 4 is set. Mode bit 6 takes precedence: the extra bit is then auxiliary bit 0 when sending, and the received extra bit appears in status bit 5.
- R3: Every bit lasts 16*(D+1) clocks, where D is the divisor at addresses 2 (low byte) and 3 (high byte). The first bit of a transmitted frame may be up to D+1 clocks shorter.
- R4: With mode bit 0 set, a received frame loads the byte into the data register (address 5) and sets status bit 0. Reading address 5 clears status bit 0.
- R5: A low level on rxd must still be low at the middle of the start bit to begin a frame. A shorter low pulse produces no frame.
- R6: Status bit 2 flags a parity mismatch and status bit 3 flags a stop bit received as 0. Status bit 4 is set when a frame completes while status bit 0 is still set; the new byte is then discarded. Writing address 4 clears all three bits.
- R7: While dcd_n is 1, the receiver is held idle and frames on rxd are ignored. Status bit 6 reads as the inverse of dcd_n.
- R8: While cts_n is 1, status bit 1 reads 0, but frames are still transmitted from the holding register.
- R9: Status bit 1 reads 1 when the holding register is empty and cts_n is 0. Writing address 5 fills the holding register. Its byte moves to the shifter when the shifter is idle.
- R10: rts_n equals the inverse of mode bit 7 on every cycle.
- R11: irq is 1 exactly when (status bit 0 and auxiliary bit 1) or (status bit 1 and auxiliary bit 2).
- R12: After reset all configuration reads 0, txd is 1, irq is 0 and rts_n is 1. Status reads 0x42 when dcd_n and cts_n are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect only at address 5) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| dcd_n | input | 1 | Carrier detect, active low |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded assertions check the following. A disabled or carrier-less receiver returns to idle. The shifter starts only from a full holding register. Every transmitted frame ends on a high line. Receive-ready rises only out of a frame's bit phase. An overrun never disturbs the byte already held. The bench's scenarios are needed for the rest: exact frame contents under each data length, parity and ninth-bit setting; bit period against the divisor; rejection of a short start pulse; error flag setting and clearing; and the fact that clear-to-send hides the status bit while the frame still goes out.

// File: rtl/serial_link_port.sv
`timescale 1ns/1ps
module serial_link_port #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd,
  input  logic       dcd_n,
  input  logic       cts_n,
  output logic       rts_n,
  output logic       irq
);
  localparam int SW = $clog2(OVS);
  localparam logic [SW-1:0] MID  = SW'(OVS / 2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OVS - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  logic [7:0]  mode_r;
  logic [2:0]  aux_r;
  logic [15:0] div_r, tick_cnt;
  logic        tick;

  wire rx_on    = mode_r[0];
  wire tx_on    = mode_r[1];
  wire len8     = mode_r[2];
  wire par_en   = mode_r[3];
  wire par_odd  = mode_r[4];
  wire two_stop = mode_r[5];
  wire mp_on    = mode_r[6];
  wire has_x    = mp_on | par_en;
  wire [3:0] dbits = len8 ? 4'd8 : 4'd7;

  wire wr_data = reg_wr && reg_addr == 3'd5;
  wire rd_data = reg_rd && reg_addr == 3'd5;
  wire wr_stat = reg_wr && reg_addr == 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= '0;
      aux_r  <= '0;
      div_r  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: mode_r <= reg_wdata;
        3'd1: aux_r <= reg_wdata[2:0];
        3'd2: div_r[7:0] <= reg_wdata;
        3'd3: div_r[15:8] <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign tick = tick_cnt >= div_r;
  always_ff @(posedge clk) begin
    if (!rst_n) tick_cnt <= '0;
    else        tick_cnt <= tick ? 16'd0 : tick_cnt + 16'd1;
  end

  // transmitter
  logic [7:0]    thr;
  logic          thr_full, tx_busy;
  logic [11:0]   tx_sh;
  logic [3:0]    tx_left;
  logic [SW-1:0] tx_sub;

  wire        tx_load = tx_on && !tx_busy && thr_full;
  wire [7:0]  tdat    = len8 ? thr : {1'b0, thr[6:0]};
  wire        tx_xb   = !has_x ? 1'b1 : (mp_on ? aux_r[0] : (^tdat ^ par_odd));
  wire [11:0] tx_frame = len8 ? {2'b11, tx_xb, thr, 1'b0}
                              : {3'b111, tx_xb, thr[6:0], 1'b0};
  wire [3:0]  tx_n = 4'd1 + dbits + {3'b0, has_x} + (two_stop ? 4'd2 : 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr <= '0; thr_full <= 1'b0; tx_busy <= 1'b0;
      tx_sh <= '1; tx_left <= '0; tx_sub <= '0;
    end else begin
      if (tx_load) begin
        tx_sh <= tx_frame; tx_left <= tx_n; tx_sub <= '0; tx_busy <= 1'b1;
      end else if (tx_busy && tick) begin
        if (tx_sub == LAST) begin
          tx_sub  <= '0;
          tx_sh   <= {1'b1, tx_sh[11:1]};
          tx_left <= tx_left - 4'd1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end else tx_sub <= tx_sub + SW'(1);
      end
      if (wr_data) begin
        thr <= reg_wdata; thr_full <= 1'b1;
      end else if (tx_load) thr_full <= 1'b0;
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // R9
  load_takes_holding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(thr_full));
  // R1
  frame_ends_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(txd));

  // receiver
  logic [1:0]    rx_sync;
  rx_st_t        rx_st;
  logic [SW-1:0] rx_sub;
  logic [3:0]    rx_idx;
  logic [8:0]    rx_buf;
  logic [7:0]    rdr;
  logic          rx_rdy, err_par, err_frm, err_ovr, mp_bit;

  wire       rx_s    = rx_sync[1];
  wire       rx_live = rx_on && !dcd_n;
  wire [3:0] rx_n    = dbits + {3'b0, has_x};
  wire       rx_done = rx_live && tick && rx_st == RX_BITS && rx_sub == LAST && rx_idx == rx_n;
  wire [7:0] rd8     = len8 ? rx_buf[7:0] : {1'b0, rx_buf[6:0]};
  wire       rxx     = len8 ? rx_buf[8] : rx_buf[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync <= 2'b11; rx_st <= RX_IDLE; rx_sub <= '0; rx_idx <= '0; rx_buf <= '0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      if (!rx_live) rx_st <= RX_IDLE;
      else if (tick) begin
        case (rx_st)
          RX_IDLE: if (!rx_s) begin rx_st <= RX_START; rx_sub <= '0; end
          RX_START:
            if (rx_sub == MID) begin
              rx_st <= rx_s ? RX_IDLE : RX_BITS; rx_sub <= '0; rx_idx <= '0;
            end else rx_sub <= rx_sub + SW'(1);
          default:
            if (rx_sub == LAST) begin
              rx_sub <= '0;
              if (rx_idx == rx_n) rx_st <= RX_IDLE;
              else begin rx_buf[rx_idx] <= rx_s; rx_idx <= rx_idx + 4'd1; end
            end else rx_sub <= rx_sub + SW'(1);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdr <= '0; rx_rdy <= 1'b0; err_par <= 1'b0; err_frm <= 1'b0; err_ovr <= 1'b0; mp_bit <= 1'b0;
    end else begin
      if (rd_data) rx_rdy <= 1'b0;
      if (rx_done) begin
        if (rx_rdy) err_ovr <= 1'b1;
        else begin
          rdr <= rd8; rx_rdy <= 1'b1;
          if (par_en && !mp_on && (^rd8 ^ rxx ^ par_odd)) err_par <= 1'b1;
          if (mp_on) mp_bit <= rxx;
          if (!rx_s) err_frm <= 1'b1;
        end
      end
      if (wr_stat) begin err_par <= 1'b0; err_frm <= 1'b0; err_ovr <= 1'b0; end
    end
  end

  // R7
  rx_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_live |=> rx_st == RX_IDLE);
  // R4
  ready_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> $past(rx_st == RX_BITS));
  // R6
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_ovr) |-> $stable(rdr) && $past(rx_rdy));

  // host side
  wire       tx_flag = !thr_full && !cts_n;
  wire [7:0] stat = {1'b0, ~dcd_n, mp_bit, err_ovr, err_frm, err_par, tx_flag, rx_rdy};

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = mode_r;
      3'd1:    reg_rdata = {5'b0, aux_r};
      3'd2:    reg_rdata = div_r[7:0];
      3'd3:    reg_rdata = div_r[15:8];
      3'd4:    reg_rdata = stat;
      3'd5:    reg_rdata = rdr;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq   = (rx_rdy & aux_r[1]) | (tx_flag & aux_r[2]);
  assign rts_n = ~mode_r[7];
endmodule

// File: tb/tb_serial_link_port.sv
`timescale 1ns/1ps
module tb_serial_link_port;
  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic rxd = 1, txd, dcd_n = 0, cts_n = 0, rts_n, irq;

  serial_link_port dut (.clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
                        .rxd, .txd, .dcd_n, .cts_n, .rts_n, .irq);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, rts_mism = 0, P = 16;
  bit c_len8 = 0, c_par = 0, c_odd = 0, c_two = 0, c_mp = 0, c_mpbit = 0, c_rts = 0;
  logic [11:0] mon_q[$];
  logic mon_prev = 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int frame_len();
    return 1 + (c_len8 ? 8 : 7) + ((c_mp || c_par) ? 1 : 0) + (c_two ? 2 : 1);
  endfunction

  function automatic logic [11:0] exp_frame(input logic [7:0] d);
    logic [11:0] f;
    int p, ones;
    f = '1; f[0] = 1'b0; p = 1; ones = 0;
    for (int i = 0; i < (c_len8 ? 8 : 7); i++) begin
      f[p] = d[i]; ones += int'(d[i]); p++;
    end
    if (c_mp) f[p] = c_mpbit;
    else if (c_par) f[p] = 1'((ones % 2) ^ int'(c_odd));
    return f;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic set_mode(input bit l8, input bit par, input bit odd, input bit two, input bit mp, input bit rts);
    c_len8 = l8; c_par = par; c_odd = odd; c_two = two; c_mp = mp;
    wr(3'd0, {rts, mp, two, odd, par, l8, 2'b11});
    c_rts = rts;
  endtask

  task automatic tx_check(input logic [7:0] d, input string req);
    logic [11:0] e;
    e = exp_frame(d);
    wr(3'd5, d);
    while (mon_q.size() == 0) @(negedge clk);
    chk(req, "tx frame", int'(mon_q.pop_front()), int'(e));
  endtask

  task automatic rx_send(input logic [11:0] f, input int nb);
    for (int i = 0; i < nb; i++) begin
      rxd = f[i];
      repeat (P) @(negedge clk);
    end
    rxd = 1;
    repeat (4) @(negedge clk);
  endtask

  // behavioural line monitor: decodes txd every clock into frames
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mon_prev && !txd) begin : cap
        logic [11:0] f;
        int nb;
        nb = frame_len(); f = '1;
        repeat (P / 2 - 1) @(negedge clk);
        f[0] = txd;
        for (int i = 1; i < nb; i++) begin
          repeat (P) @(negedge clk);
          f[i] = txd;
        end
        mon_q.push_back(f);
      end
      mon_prev = txd;
    end
  end

  always @(negedge clk) if (rst_n && (rts_n !== ~c_rts)) rts_mism++;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [11:0] f;
    int cnt;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd4, v); chk("R12", "reset status", v, 8'h42);
    rd(3'd0, v); chk("R12", "reset mode", v, 0);
    chk("R12", "reset txd", txd, 1);
    chk("R12", "reset irq", irq, 0);
    chk("R12", "reset rts_n", rts_n, 1);

    wr(3'd2, 8'd3); wr(3'd3, 8'd0); P = 64;
    set_mode(1, 0, 0, 0, 0, 1);
    @(negedge clk); chk("R10", "rts asserted", rts_n, 0);
    set_mode(1, 0, 0, 0, 0, 0);
    @(negedge clk); chk("R10", "rts released", rts_n, 1);

    tx_check(8'hA5, "R1 8N1");
    set_mode(0, 1, 0, 1, 0, 0); tx_check(8'h53, "R1 R2 7E2");
    set_mode(1, 1, 1, 0, 0, 0); tx_check(8'h00, "R2 8O1");
    c_mpbit = 1; wr(3'd1, 8'h01);
    set_mode(1, 0, 0, 0, 1, 0); tx_check(8'h81, "R2 ninth bit");
    wr(3'd1, 8'h00);
    rd(3'd4, v); chk("R9", "tx ready when empty", int'(v[1]), 1);

    // receive
    set_mode(1, 0, 0, 0, 0, 0);
    rx_send(exp_frame(8'h3C), frame_len());
    rd(3'd4, v); chk("R4", "rx ready set", int'(v[0]), 1);
    rd(3'd5, v); chk("R4", "rx data", v, 8'h3C);
    rd(3'd4, v); chk("R4", "rx ready cleared by read", int'(v[0]), 0);

    set_mode(1, 0, 0, 0, 1, 0); c_mpbit = 1;
    rx_send(exp_frame(8'h11), frame_len());
    rd(3'd4, v); chk("R2", "received ninth bit", int'(v[5]), 1);
    rd(3'd5, v); chk("R2", "ninth-bit frame data", v, 8'h11);
    c_mpbit = 0;

    set_mode(1, 1, 0, 0, 0, 0);
    f = exp_frame(8'h07); f[9] = ~f[9];
    rx_send(f, frame_len());
    rd(3'd4, v); chk("R6", "parity error", int'(v[2]), 1);
    rd(3'd5, v); chk("R6", "data kept on parity error", v, 8'h07);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R6", "parity error cleared", int'(v[2]), 0);

    set_mode(1, 0, 0, 0, 0, 0);
    f = exp_frame(8'h5A); f[9] = 1'b0;
    rx_send(f, frame_len());
    repeat (P) @(negedge clk);
    rd(3'd4, v); chk("R6", "framing error", int'(v[3]), 1);
    rd(3'd5, v);
    wr(3'd0, 8'h06); set_mode(1, 0, 0, 0, 0, 0);
    wr(3'd4, 8'h00);

    rx_send(exp_frame(8'h44), frame_len());
    rx_send(exp_frame(8'h55), frame_len());
    rd(3'd4, v); chk("R6", "overrun flag", int'(v[4]), 1);
    rd(3'd5, v); chk("R6", "overrun keeps first byte", v, 8'h44);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R6", "status after clear", int'(v[4:0]), 5'b00010);

    dcd_n = 1;
    rd(3'd4, v); chk("R7", "carrier bit low", int'(v[6]), 0);
    rx_send(exp_frame(8'h66), frame_len());
    rd(3'd4, v); chk("R7", "no frame without carrier", int'(v[0]), 0);
    dcd_n = 0;
    repeat (P) @(negedge clk);
    rx_send(exp_frame(8'h77), frame_len());
    rd(3'd5, v); chk("R7", "frame after carrier returns", v, 8'h77);

    rxd = 0; repeat (12) @(negedge clk); rxd = 1;
    repeat (3 * P) @(negedge clk);
    rd(3'd4, v); chk("R5", "short start pulse ignored", int'(v[0]), 0);
    rx_send(exp_frame(8'h5A), frame_len());
    rd(3'd5, v); chk("R5", "frame after glitch", v, 8'h5A);

    cts_n = 1;
    rd(3'd4, v); chk("R8", "tx ready hidden", int'(v[1]), 0);
    tx_check(8'h3E, "R8 sends while cts high");
    rd(3'd4, v); chk("R8", "tx ready still hidden", int'(v[1]), 0);
    cts_n = 0;
    rd(3'd4, v); chk("R8", "tx ready back", int'(v[1]), 1);

    wr(3'd1, 8'h02);
    @(negedge clk); chk("R11", "irq idle", irq, 0);
    rx_send(exp_frame(8'h21), frame_len());
    chk("R11", "irq on rx ready", irq, 1);
    rd(3'd5, v);
    @(negedge clk); chk("R11", "irq after read", irq, 0);
    wr(3'd1, 8'h04);
    @(negedge clk); chk("R11", "irq on tx ready", irq, 1);
    cts_n = 1;
    @(negedge clk); chk("R11", "irq masked by cts", irq, 0);
    cts_n = 0;
    wr(3'd1, 8'h00);

    wr(3'd2, 8'd7); P = 128;
    repeat (8) @(negedge clk);
    wr(3'd5, 8'hFF);
    while (txd) @(negedge clk);
    cnt = 0;
    while (!txd) begin cnt++; @(negedge clk); end
    chk("R3", "start bit length in range", int'(cnt >= 120 && cnt <= 128), 1);
    while (mon_q.size() == 0) @(negedge clk);
    chk("R3", "frame at slower rate", int'(mon_q.pop_front()), int'(exp_frame(8'hFF)));

    chk("R10", "rts per-cycle mismatches", rts_mism, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule